// File: doc/BRIEF.md
# Cache-Line Access Counter and Event Logger

This block keeps, for each of a small set of second-level cache lines, an access counter, a two-bit event flag, a tag and a data/instruction marker. In normal mode every data hit on a data line bumps that line's counter. When a coherence event reaches the line, the block emits one record on a log write port. An event here is either an ejection (eviction or invalidation) or a remote read of a locally dirty line. The record carries the line's extended tag (its tag with the line index appended), the counter value and an event code. The counter then restarts from zero. The records form an audit trail of how many accesses each line saw between coherence events.

In replay mode, a reload port installs a logged counter and code into a line. Each later hit counts the line down. A hit that finds the counter already at zero signals the logged event on a replay output. When a record is due and the log already holds its full number of entries, the block writes nothing and raises a checkpoint request instead. A checkpoint-complete input empties the log by clearing its index.

Top module: `line_audit_logger`

## Requirements
- R1: After reset, log_we, ckpt_req and fire_valid are 0. The first record written goes to log address 0.
- R2: In normal mode, each hit (acc_op 2'b00) on a data line adds one to its counter. An ejection (acc_op 2'b10) on a data line writes, one cycle later, a record with the counter, code 2'b10 and ext tag {tag, line}.
- R3: A remote read of a dirty line (acc_op 2'b01) on a data line writes a record with the counter and code 2'b01.
- R4: After a record is written for a line, that line's counter is 0 and its flag is no-event (2'b00).
- R5: A normal-mode hit on a line whose counter is all ones writes a record with that value and code 2'b11 (counter overflow), instead of wrapping the counter.
- R6: Accesses to lines marked instruction (fill_data 0) change no counter and write no record.
- R7: Records go to consecutive addresses. When a record is due and the index already equals LOG_DEPTH (8192), log_we stays 0 and ckpt_req pulses for one cycle instead.
- R8: A ckpt_done pulse sets the log index to 0, so the next record is written at address 0.
- R9: In replay mode, a reload sets a line's counter and flag. Each hit decrements the counter. A hit with the counter at 0 and a flag other than 2'b00 pulses fire_valid one cycle later, with the line and the logged code.
- R10: In replay mode, no access writes a record and no access requests a checkpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| replay_mode | input | 1 | 1 selects replay, 0 selects normal logging |
| fill_valid | input | 1 | Install a line |
| fill_line | input | LW | Line index being installed |
| fill_tag | input | TAG_W | Tag of the installed block |
| fill_data | input | 1 | 1 marks a data line, 0 an instruction line |
| acc_valid | input | 1 | Access or coherence event present |
| acc_line | input | LW | Line the access targets |
| acc_op | input | 2 | 00 hit, 01 remote dirty read, 10 ejection, 11 none |
| ld_valid | input | 1 | Replay reload from the log read port |
| ld_line | input | LW | Line to reload |
| ld_cnt | input | CNT_W | Logged counter value |
| ld_code | input | 2 | Logged event code |
| ckpt_done | input | 1 | Checkpoint finished; clears the log index |
| log_we | output | 1 | Record write strobe |
| log_addr | output | IDX_W | Record address |
| log_tag | output | TAG_W+LW | Extended tag {tag, line} |
| log_cnt | output | CNT_W | Logged counter value |
| log_code | output | 2 | 01 remote read, 10 ejection, 11 overflow |
| ckpt_req | output | 1 | Log full when a record was due |
| fire_valid | output | 1 | Replayed event due |
| fire_line | output | LW | Line of the replayed event |
| fire_code | output | 2 | Code of the replayed event |

## Verification
Hit bursts of different lengths precede ejections and remote reads on several lines. These show that the counter value and the event code are recorded, and that counts from different lines do not mix. Back-to-back events on the same line confirm that the counter restarts. A reload at all ones, followed by a normal hit, exercises the overflow code without billions of cycles. Filling the log to 8192 records separates a write at the last free entry from the checkpoint request that follows. A replay sequence checks that no event fires before the counter runs out and that the event fires exactly when it does.

// File: rtl/line_audit_logger.sv
module line_audit_logger #(
  parameter int LINES     = 8,
  parameter int TAG_W     = 20,
  parameter int CNT_W     = 32,
  parameter int LOG_DEPTH = 8192,
  localparam int LW       = $clog2(LINES),
  localparam int IDX_W    = $clog2(LOG_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                replay_mode,
  input  logic                fill_valid,
  input  logic [LW-1:0]       fill_line,
  input  logic [TAG_W-1:0]    fill_tag,
  input  logic                fill_data,
  input  logic                acc_valid,
  input  logic [LW-1:0]       acc_line,
  input  logic [1:0]          acc_op,
  input  logic                ld_valid,
  input  logic [LW-1:0]       ld_line,
  input  logic [CNT_W-1:0]    ld_cnt,
  input  logic [1:0]          ld_code,
  input  logic                ckpt_done,
  output logic                log_we,
  output logic [IDX_W-1:0]    log_addr,
  output logic [TAG_W+LW-1:0] log_tag,
  output logic [CNT_W-1:0]    log_cnt,
  output logic [1:0]          log_code,
  output logic                ckpt_req,
  output logic                fire_valid,
  output logic [LW-1:0]       fire_line,
  output logic [1:0]          fire_code
);
  localparam logic [1:0] OP_HIT = 2'b00, OP_RRD = 2'b01, OP_EJ = 2'b10;
  localparam logic [1:0] EV_NONE = 2'b00, EV_RRD = 2'b01, EV_EJ = 2'b10, EV_OVF = 2'b11;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] FULL = IDX_W'(LOG_DEPTH);

  logic [CNT_W-1:0] cnt  [LINES];
  logic [1:0]       flg  [LINES];
  logic [TAG_W-1:0] tagr [LINES];
  logic [LINES-1:0] is_data;
  logic [IDX_W-1:0] idx;

  logic [CNT_W-1:0] cur_cnt;
  logic [1:0]       cur_flg;
  logic             act, rec_due;
  logic [1:0]       rec_code;

  assign cur_cnt = cnt[acc_line];
  assign cur_flg = flg[acc_line];
  assign act     = acc_valid && is_data[acc_line];

  always_comb begin
    rec_due  = 1'b0;
    rec_code = EV_NONE;
    if (act && !replay_mode) begin
      case (acc_op)
        OP_HIT: if (cur_cnt == CNT_MAX) begin rec_due = 1'b1; rec_code = EV_OVF; end
        OP_RRD: begin rec_due = 1'b1; rec_code = EV_RRD; end
        OP_EJ:  begin rec_due = 1'b1; rec_code = EV_EJ;  end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      log_we     <= 1'b0;
      log_addr   <= '0;
      log_tag    <= '0;
      log_cnt    <= '0;
      log_code   <= EV_NONE;
      ckpt_req   <= 1'b0;
      fire_valid <= 1'b0;
      fire_line  <= '0;
      fire_code  <= EV_NONE;
      is_data    <= '0;
      for (int i = 0; i < LINES; i++) begin
        cnt[i]  <= '0;
        flg[i]  <= EV_NONE;
        tagr[i] <= '0;
      end
    end else begin
      log_we     <= 1'b0;
      ckpt_req   <= 1'b0;
      fire_valid <= 1'b0;
      if (fill_valid) begin
        tagr[fill_line]    <= fill_tag;
        is_data[fill_line] <= fill_data;
        cnt[fill_line]     <= '0;
        flg[fill_line]     <= EV_NONE;
      end
      if (ld_valid) begin
        cnt[ld_line]     <= ld_cnt;
        flg[ld_line]     <= ld_code;
        is_data[ld_line] <= 1'b1;
      end
      if (rec_due) begin
        if (idx == FULL) begin
          ckpt_req <= 1'b1;
        end else begin
          log_we        <= 1'b1;
          log_addr      <= idx;
          log_tag       <= {tagr[acc_line], acc_line};
          log_cnt       <= cur_cnt;
          log_code      <= rec_code;
          idx           <= idx + 1'b1;
          cnt[acc_line] <= '0;
          flg[acc_line] <= EV_NONE;
        end
      end else if (act && !replay_mode && acc_op == OP_HIT) begin
        cnt[acc_line] <= cur_cnt + 1'b1;
      end else if (act && replay_mode && acc_op == OP_HIT) begin
        if (cur_cnt == '0) begin
          if (cur_flg != EV_NONE) begin
            fire_valid <= 1'b1;
            fire_line  <= acc_line;
            fire_code  <= cur_flg;
          end
          flg[acc_line] <= EV_NONE;
        end else begin
          cnt[acc_line] <= cur_cnt - 1'b1;
        end
      end
      if (ckpt_done) idx <= '0;
    end
  end
endmodule

// File: rtl/line_audit_logger_chk.sv
module line_audit_logger_chk #(
  parameter int LW    = 3,
  parameter int IDX_W = 14,
  parameter int LOG_DEPTH = 8192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             replay_mode,
  input logic             acc_valid,
  input logic             ckpt_done,
  input logic             log_we,
  input logic [IDX_W-1:0] log_addr,
  input logic [1:0]       log_code,
  input logic             ckpt_req,
  input logic             fire_valid,
  input logic [1:0]       fire_code
);
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(log_we && ckpt_req));
  p_addr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    log_we |-> log_addr < IDX_W'(LOG_DEPTH));
  p_consecutive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (log_we && $past(log_we) && !$past(ckpt_done)) |-> log_addr == $past(log_addr) + 1'b1);
  p_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_done && !log_we) |=> !log_we || log_addr == '0);
  p_code_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    log_we |-> log_code != 2'b00);
  p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (log_we || ckpt_req) |-> $past(acc_valid));
  p_quiet_replay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (log_we || ckpt_req) |-> !$past(replay_mode));
  p_fire_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |-> ($past(replay_mode) && fire_code != 2'b00));
endmodule

bind line_audit_logger line_audit_logger_chk #(.LW(LW), .IDX_W(IDX_W), .LOG_DEPTH(LOG_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .replay_mode(replay_mode), .acc_valid(acc_valid),
  .ckpt_done(ckpt_done), .log_we(log_we), .log_addr(log_addr), .log_code(log_code),
  .ckpt_req(ckpt_req), .fire_valid(fire_valid), .fire_code(fire_code));

// File: tb/line_audit_logger_bench.sv
module line_audit_logger_bench;
  localparam int LW = 3, TAG_W = 20, CNT_W = 32, IDX_W = 14, DEPTH = 8192;

  logic clk = 0, rst_n = 0, replay_mode = 0;
  logic fill_valid = 0, fill_data = 0;
  logic [LW-1:0] fill_line = 0, acc_line = 0, ld_line = 0;
  logic [TAG_W-1:0] fill_tag = 0;
  logic acc_valid = 0, ld_valid = 0, ckpt_done = 0;
  logic [1:0] acc_op = 2'b11, ld_code = 0;
  logic [CNT_W-1:0] ld_cnt = 0;
  logic log_we, ckpt_req, fire_valid;
  logic [IDX_W-1:0] log_addr;
  logic [TAG_W+LW-1:0] log_tag;
  logic [CNT_W-1:0] log_cnt;
  logic [1:0] log_code, fire_code;
  logic [LW-1:0] fire_line;

  int checks = 0, fails = 0;
  int nxt = 0;

  always #10 clk = ~clk;

  line_audit_logger u_line_audit_logger (
    .clk, .rst_n, .replay_mode, .fill_valid, .fill_line, .fill_tag, .fill_data,
    .acc_valid, .acc_line, .acc_op, .ld_valid, .ld_line, .ld_cnt, .ld_code,
    .ckpt_done, .log_we, .log_addr, .log_tag, .log_cnt, .log_code, .ckpt_req,
    .fire_valid, .fire_line, .fire_code);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input int line, input int tag, input logic d);
    fill_valid = 1; fill_line = LW'(line); fill_tag = TAG_W'(tag); fill_data = d;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic acc(input int line, input logic [1:0] op);
    acc_valid = 1; acc_line = LW'(line); acc_op = op;
    @(negedge clk); acc_valid = 0; acc_op = 2'b11;
  endtask

  task automatic hits(input int line, input int n);
    for (int i = 0; i < n; i++) acc(line, 2'b00);
  endtask

  task automatic expect_rec(input string req, input int line, input int tag,
                            input logic [31:0] c, input logic [1:0] code);
    chk(req, log_we, 1);
    chk(req, log_addr, 64'(nxt));
    chk(req, log_tag, {TAG_W'(tag), LW'(line)});
    chk(req, log_cnt, c);
    chk(req, log_code, code);
    nxt++;
  endtask

  task automatic t_reset;
    chk("R1", {log_we, ckpt_req, fire_valid}, 0);
  endtask

  task automatic t_eject;
    fill(2, 'hABCDE, 1); fill(5, 'h12345, 1);
    hits(2, 3); hits(5, 1);
    acc(2, 2'b10); expect_rec("R2", 2, 'hABCDE, 3, 2'b10);
    hits(5, 4);
    acc(5, 2'b01); expect_rec("R3", 5, 'h12345, 5, 2'b01);
    acc(2, 2'b10); expect_rec("R4", 2, 'hABCDE, 0, 2'b10);
    hits(5, 2);
    acc(5, 2'b10); expect_rec("R4", 5, 'h12345, 2, 2'b10);
  endtask

  task automatic t_instr;
    fill(1, 'h777, 0);
    hits(1, 2); chk("R6", log_we, 0);
    acc(1, 2'b10); chk("R6", log_we, 0);
    acc(1, 2'b01); chk("R6", log_we, 0);
    fill(1, 'h777, 1);
    acc(1, 2'b10); expect_rec("R6", 1, 'h777, 0, 2'b10);
  endtask

  task automatic t_overflow;
    fill(3, 'h333, 1);
    ld_valid = 1; ld_line = 3; ld_cnt = '1; ld_code = 0;
    @(negedge clk); ld_valid = 0;
    acc(3, 2'b00); expect_rec("R5", 3, 'h333, 32'hFFFFFFFF, 2'b11);
    acc(3, 2'b10); expect_rec("R5", 3, 'h333, 0, 2'b10);
  endtask

  task automatic t_replay;
    fill(4, 'h444, 1);
    replay_mode = 1;
    ld_valid = 1; ld_line = 4; ld_cnt = 2; ld_code = 2'b01;
    @(negedge clk); ld_valid = 0;
    acc(4, 2'b00); chk("R9", fire_valid, 0);
    acc(4, 2'b00); chk("R9", fire_valid, 0);
    acc(4, 2'b00);
    chk("R9", fire_valid, 1); chk("R9", fire_line, 4); chk("R9", fire_code, 2'b01);
    acc(4, 2'b00); chk("R9", fire_valid, 0);
    acc(4, 2'b10); chk("R10", {log_we, ckpt_req}, 0);
    acc(4, 2'b01); chk("R10", {log_we, ckpt_req}, 0);
    replay_mode = 0;
  endtask

  task automatic t_full;
    int bad = 0;
    fill(6, 'h666, 1);
    for (int i = nxt; i < DEPTH; i++) begin
      acc(6, 2'b10);
      if (!log_we || log_addr != IDX_W'(i)) bad++;
    end
    chk("R7", 64'(bad), 0);
    chk("R7", log_addr, DEPTH - 1);
    acc(6, 2'b10);
    chk("R7", log_we, 0); chk("R7", ckpt_req, 1);
    @(negedge clk); chk("R7", ckpt_req, 0);
    ckpt_done = 1; @(negedge clk); ckpt_done = 0;
    nxt = 0;
    hits(6, 1);
    acc(6, 2'b10); expect_rec("R8", 6, 'h666, 1, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_eject;
    t_instr;
    t_overflow;
    t_replay;
    t_full;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule